// File: doc/BRIEF.md
# Serial Control Register Port

This block lets an external microcontroller configure a codec-style device through a slow three-wire serial link. A transfer is framed by an active-high enable. The host presents bits on a serial data input and clocks them in with a shift clock. Every frame starts with a one-bit direction flag, followed by a three-bit register address. A write frame then carries eight data bits. A read frame instead makes the port return the addressed register on a serial output. The returned value is bit-inverted and sent most significant bit first. A separate output-enable tells the pad when that output is actually driven.

The port holds seven writable 8-bit control registers and one read-only status register. The writable registers are flattened onto a control bus for the rest of the chip. The status register reflects a voice-activity flag and a two-bit noise indicator. All external serial signals are sampled into the system clock domain through synchronizers. All register updates happen on that clock, and a synchronous active-high reset restores the power-up contents.

Top module: `ctrl_serial_port`

## Requirements
- R1: A frame consists of the shift-clock rising edges seen while `frame_en` is high. Bits are sampled on rising edges in this order: direction flag (1 = write, 0 = read), address bit 2, bit 1, bit 0, then data bit 7 down to bit 0.
- R2: A write frame with exactly 12 rising edges updates the addressed register once `frame_en` falls. Register k then appears on `ctrl_flat[8k+7:8k]` (k = 0..6) and reads back with the written value.
- R3: After reset, register 2 holds 0x33 and registers 0, 1, 3, 4, 5 and 6 hold 0x00.
- R4: A write frame with fewer or more than 12 rising edges changes no register.
- R5: A write frame addressed to 7 changes no register, and address 7 still reads the status value afterwards.
- R6: In a read frame, `ser_out` presents the bitwise inverse of the addressed register, bit 7 first. Each bit is valid at rising edges 5 to 12, and bits change after falling edges.
- R7: `ser_oe` is high only during a read frame, from the falling edge after the fourth rising edge until the falling edge after the twelfth. It is low during idle, during header bits, during write frames, and once `frame_en` drops.
- R8: Address 7 reads as {`vox_flag`, `noise_lvl[1]`, `noise_lvl[0]`, 5'b00000}, taken from the live status inputs.
- R9: Asserting `rst` after writes returns every writable register to its value listed in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (external reset / power-down pin) |
| shift_clk | input | 1 | Serial shift clock from the host, asynchronous |
| frame_en | input | 1 | Active-high frame enable from the host |
| ser_in | input | 1 | Serial flag, address and write data |
| ser_out | output | 1 | Serial read data, inverted register contents |
| ser_oe | output | 1 | High when `ser_out` must be driven onto the pad |
| vox_flag | input | 1 | Voice-activity result for status bit 7 |
| noise_lvl | input | 2 | Noise-level indicator for status bits 6:5 |
| ctrl_flat | output | 56 | Writable registers 0..6, register k in bits 8k+7:8k |

## Verification
The hardest conditions to reach from the ports are frames that end on the wrong edge count, and a write aimed at the status address. The stimulus builds these deliberately. One frame is cut off after seven edges. Another gets a thirteenth edge after a valid-looking write header. A third targets address 7. Each is followed by a read and a look at the control bus, to prove that nothing moved. Reads of the status address are repeated under different status input patterns. This shows that the inverted value tracks the live inputs rather than a stored write.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  function automatic logic [DATA_W-1:0] init_value(input int idx);
    return (idx == 2) ? 8'h33 : 8'h00;
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign cur  = s2;
  assign prev = s3;
endmodule

// File: rtl/frame_engine.sv
module frame_engine #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          en_lvl,
  input  logic          en_fall,
  input  logic          sdi_lvl,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int HDR   = 1 + AW;
  localparam int FRAME = HDR + DW;
  localparam int SAT   = FRAME + 1;
  localparam int CW    = $clog2(SAT + 1);
  localparam logic [AW-1:0] RO_ADDR = {AW{1'b1}};

  logic [CW-1:0]    cnt_q;
  logic [FRAME-1:0] sh_q;
  logic [DW-1:0]    out_q;

  assign rd_addr = sh_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (en_fall && cnt_q == CW'(FRAME) && sh_q[FRAME-1] &&
          sh_q[FRAME-2 -: AW] != RO_ADDR) begin
        wr_en   <= 1'b1;
        wr_addr <= sh_q[FRAME-2 -: AW];
        wr_data <= sh_q[DW-1:0];
      end
      if (!en_lvl) begin
        cnt_q  <= '0;
        sdo_oe <= 1'b0;
      end else begin
        if (sclk_rise) begin
          sh_q <= {sh_q[FRAME-2:0], sdi_lvl};
          if (cnt_q != CW'(SAT)) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall) begin
          if (cnt_q == CW'(HDR) && !sh_q[AW]) begin
            sdo    <= ~rd_word[DW-1];
            out_q  <= {~rd_word[DW-2:0], 1'b0};
            sdo_oe <= 1'b1;
          end else if (sdo_oe && cnt_q < CW'(FRAME)) begin
            sdo   <= out_q[DW-1];
            out_q <= {out_q[DW-2:0], 1'b0};
          end else if (sdo_oe) begin
            sdo_oe <= 1'b0;
          end
        end
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(SAT));
  assert_oe_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(cnt_q) == CW'(HDR));
  assert_oe_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !en_lvl |=> !sdo_oe);
  assert_write_full_frame_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(cnt_q) == CW'(FRAME));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import ctrl_port_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NREG = 1 << AW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_word,
  input  logic                   vox_flag,
  input  logic [1:0]             noise_lvl,
  output logic [(NREG-1)*DW-1:0] flat
);
  localparam int NWR = NREG - 1;

  logic [DW-1:0] regs [NREG];

  for (genvar k = 0; k < NWR; k++) begin : g_reg
    localparam logic [DW-1:0] RV = DW'(init_value(k));
    always_ff @(posedge clk) begin
      if (rst)                                   regs[k] <= RV;
      else if (wr_en && wr_addr == AW'(k))       regs[k] <= wr_data;
    end
    assign flat[k*DW +: DW] = regs[k];
  end

  always_ff @(posedge clk) begin
    if (rst) regs[NWR] <= '0;
    else     regs[NWR] <= {vox_flag, noise_lvl, {(DW-3){1'b0}}};
  end

  assign rd_word = regs[rd_addr];

  assert_ro_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_addr != AW'(NWR));
  assert_reset_vals_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs[2] == DW'(init_value(2)) && regs[0] == '0));
endmodule

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port
  import ctrl_port_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int NREG = 1 << AW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_clk,
  input  logic                   frame_en,
  input  logic                   ser_in,
  output logic                   ser_out,
  output logic                   ser_oe,
  input  logic                   vox_flag,
  input  logic [1:0]             noise_lvl,
  output logic [(NREG-1)*DW-1:0] ctrl_flat
);
  logic [2:0]    cur, prev;
  logic          sclk_rise, sclk_fall, en_fall;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_word, wr_data;
  logic          wr_en;

  edge_sync #(.W(3)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ser_in, frame_en, shift_clk}),
    .cur(cur), .prev(prev)
  );

  assign sclk_rise = cur[0] & ~prev[0];
  assign sclk_fall = ~cur[0] & prev[0];
  assign en_fall   = ~cur[1] & prev[1];

  frame_engine #(.DW(DW), .AW(AW)) u_eng (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .en_lvl(cur[1]), .en_fall(en_fall), .sdi_lvl(cur[2]),
    .rd_word(rd_word), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(ser_out), .sdo_oe(ser_oe)
  );

  reg_bank #(.DW(DW), .AW(AW), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .vox_flag(vox_flag), .noise_lvl(noise_lvl),
    .flat(ctrl_flat)
  );

  assert_oe_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> $past(cur[1]));
endmodule

// File: tb/ctrl_serial_port_bench.sv
`timescale 1ns/100ps
module ctrl_serial_port_bench;
  logic clk = 0, rst = 1;
  logic sclk = 0, en = 0, sdi = 0;
  logic vox = 0;
  logic [1:0] lvl = 0;
  logic sdo, oe;
  logic [55:0] flat;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [7];
  logic [7:0] expq [$];
  string      tagq [$];
  bit done = 0;

  always #2.5 clk = ~clk;

  ctrl_serial_port u_ctrl_serial_port (
    .clk(clk), .rst(rst), .shift_clk(sclk), .frame_en(en), .ser_in(sdi),
    .ser_out(sdo), .ser_oe(oe), .vox_flag(vox), .noise_lvl(lvl),
    .ctrl_flat(flat)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: nbits edges of {flag, addr, data}, extra edges carry 0.
  task automatic xfer(input logic rw, input logic [2:0] a, input logic [7:0] d,
                      input int nbits);
    logic [11:0] word;
    word = {rw, a, d};
    @(negedge clk); en = 1;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 12) ? word[11-i] : 1'b0;
      repeat (8) @(negedge clk); sclk = 1;
      repeat (8) @(negedge clk); sclk = 0;
    end
    repeat (8) @(negedge clk); en = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d, input int nbits);
    if (nbits == 12 && a != 3'd7) model[a] = d;
    xfer(1'b1, a, d, nbits);
  endtask

  task automatic do_read(input logic [2:0] a, input string tag);
    logic [7:0] v;
    v = (a == 3'd7) ? {vox, lvl, 5'b0} : model[a];
    expq.push_back(~v);
    tagq.push_back(tag);
    xfer(1'b0, a, 8'h00, 12);
  endtask

  task automatic chk_flat(input string tag);
    logic [55:0] e;
    for (int k = 0; k < 7; k++) e[k*8 +: 8] = model[k];
    chk(flat == e, tag, flat, e);
  endtask

  // Monitor
  int mon_rise = 0;
  logic mon_rd = 0;
  logic [7:0] mon_byte = 0;
  always @(posedge en) begin mon_rise = 0; mon_byte = 0; mon_rd = 0; end
  always @(posedge sclk) if (en) begin
    mon_rise++;
    if (mon_rise == 1) mon_rd = !sdi;
    chk(oe == (mon_rd && mon_rise >= 5 && mon_rise <= 12), "R7 oe window",
        oe, (mon_rd && mon_rise >= 5 && mon_rise <= 12));
    if (mon_rd && mon_rise >= 5 && mon_rise <= 12) mon_byte = {mon_byte[6:0], sdo};
  end
  always @(negedge en) if (mon_rd && mon_rise == 12) begin
    if (expq.size() == 0) chk(0, "R6 unexpected read", mon_byte, 0);
    else begin
      logic [7:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(mon_byte == e, t, mon_byte, e);
    end
  end

  initial begin
    #1_000_000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 7; k++) model[k] = (k == 2) ? 8'h33 : 8'h00;
    repeat (5) @(negedge clk); rst = 0;
    repeat (5) @(negedge clk);
    chk_flat("R3 reset values");
    chk(oe == 0, "R7 idle oe", oe, 0);
    do_read(3'd2, "R3 R6 read reg2");
    do_read(3'd0, "R6 read reg0");
    do_write(3'd0, 8'hA5, 12); chk_flat("R1 R2 write reg0");
    do_read(3'd0, "R2 R6 readback reg0");
    do_write(3'd5, 8'h3C, 12); do_write(3'd6, 8'hFF, 12);
    chk_flat("R2 write reg5 reg6");
    do_read(3'd5, "R6 read reg5"); do_read(3'd6, "R6 read reg6");
    do_write(3'd1, 8'h77, 7);  chk_flat("R4 short frame");
    do_write(3'd1, 8'h77, 13); chk_flat("R4 long frame");
    do_read(3'd1, "R4 reg1 unchanged");
    do_write(3'd7, 8'h55, 12); chk_flat("R5 write to status");
    do_read(3'd7, "R5 status after write");
    vox = 1; lvl = 2'b10; repeat (4) @(negedge clk);
    do_read(3'd7, "R8 status vox lvl2");
    vox = 0; lvl = 2'b01; repeat (4) @(negedge clk);
    do_read(3'd7, "R8 status lvl1");
    chk(oe == 0, "R7 oe after frames", oe, 0);
    @(negedge clk); rst = 1; repeat (3) @(negedge clk); rst = 0;
    for (int k = 0; k < 7; k++) model[k] = (k == 2) ? 8'h33 : 8'h00;
    repeat (3) @(negedge clk);
    chk_flat("R9 reset after writes");
    do_read(3'd0, "R9 reg0 cleared");
    chk(expq.size() == 0, "R6 reads outstanding", expq.size(), 0);
    finish_run();
  end
endmodule